// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with condition flags

This block performs the data operations of a small eight-bit processor: addition, subtraction, bitwise AND, OR and inversion, comparison, and logical shifts in either direction. Each cycle the caller presents a 4-bit opcode, a mode bit, the current value of the destination register and a second operand. The caller has already chosen whether that operand comes from a register or from an immediate field. The unit returns the result combinationally, together with a write-back strobe. It also keeps three condition flags in a register: zero, carry and negative.

The flags change only at the clock edge that accepts a flag-affecting operation. Compare updates the flags but never asks for a write-back. Opcodes that belong to moves, memory access, branches, port output or halt pass through the unit with no effect. A sequencer can therefore feed every decoded instruction to the unit without filtering it first.

Top module: `alu8_flags_unit`

## Requirements
- R1: Opcode 0x3 (add) gives result = (dst + operand) mod 2^WIDTH with wr_en high. The carry flag takes the carry out of the top bit.
- R2: Opcode 0x4 (subtract) gives result = (dst - operand) mod 2^WIDTH with wr_en high. The carry flag is set exactly when dst is unsigned-less-than operand (borrow).
- R3: Opcode 0x5 gives dst AND operand, and opcode 0x6 gives dst OR operand. Both raise wr_en and clear the carry flag.
- R4: Opcode 0x7 with mode 0 gives the bitwise inverse of dst, whatever the operand. With mode 1 it gives the bitwise inverse of the operand. Both raise wr_en and clear the carry flag.
- R5: Opcode 0x8 (compare) updates all three flags exactly as subtract would, but keeps wr_en low.
- R6: Opcode 0xA shifts dst left when mode is 0 and right when mode is 1. The shift amount is the whole operand taken as an unsigned number. Vacated bits fill with zero, and any amount of WIDTH or more gives zero. wr_en is high.
- R7: For a shift, the carry flag takes the last bit shifted out of dst. That is bit WIDTH-amount for a left shift and bit amount-1 for a right shift when 1 <= amount <= WIDTH. Carry is 0 when the amount is 0 or greater than WIDTH.
- R8: At the rising edge that accepts a flag-affecting operation (op_valid high), zero becomes (result == 0) and negative becomes the top bit of the result. The new flags are visible after that edge.
- R9: Opcodes 0x0, 0x1, 0x2, 0x9, 0xB to 0xF keep wr_en low and leave the flags unchanged.
- R10: While op_valid is low, wr_en is low and the flags hold their value.
- R11: An active-low reset clears all three flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_valid | input | 1 | The inputs carry an operation this cycle |
| opcode | input | 4 | Operation code |
| mode | input | 1 | Variant select for inversion and shift direction |
| dst_val | input | WIDTH | Destination register value, first source |
| operand | input | WIDTH | Second source or shift amount, already selected by the caller |
| result | output | WIDTH | Operation result (combinational) |
| wr_en | output | 1 | Result should be written to the destination |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow / shifted-out flag |
| flag_n | output | 1 | Negative flag (top result bit) |

## Verification
The bench builds the unit with its default WIDTH of 8. At that width the wrap points 0xFF+1 and 0x00-1 can be reached directly, and so can the sign boundary between 0x7F and 0x80. The width also puts the shift-amount edges within reach: 0, 1, exactly 8, 9, and a large value such as 200. At those edges the carry either comes from bit 0 or bit 7 or drops to zero. The bench interleaves compare, non-arithmetic opcodes and idle cycles between flag-setting operations. A flag that is wrongly updated or wrongly held then shows up in the next check.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OPC_ADD   = 4'h3,
    OPC_SUB   = 4'h4,
    OPC_AND   = 4'h5,
    OPC_OR    = 4'h6,
    OPC_INV   = 4'h7,
    OPC_CMP   = 4'h8,
    OPC_SHIFT = 4'hA
  } opc_e;

  typedef enum logic [1:0] {
    UNIT_NONE,
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_SHIFT
  } unit_e;

  typedef enum logic [1:0] {
    LOP_AND,
    LOP_OR,
    LOP_INV_DST,
    LOP_INV_OPND
  } lop_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
  } flags_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       mode,
  output unit_e      unit_sel,
  output logic       do_sub,
  output lop_e       lop_sel,
  output logic       shift_right,
  output logic       write_back,
  output logic       flag_upd
);

  always_comb begin
    unit_sel    = UNIT_NONE;
    do_sub      = 1'b0;
    lop_sel     = LOP_AND;
    shift_right = 1'b0;
    write_back  = 1'b0;
    flag_upd    = 1'b0;
    case (opcode)
      OPC_ADD: begin
        unit_sel   = UNIT_ARITH;
        write_back = 1'b1;
        flag_upd   = 1'b1;
      end
      OPC_SUB: begin
        unit_sel   = UNIT_ARITH;
        do_sub     = 1'b1;
        write_back = 1'b1;
        flag_upd   = 1'b1;
      end
      OPC_AND: begin
        unit_sel   = UNIT_LOGIC;
        lop_sel    = LOP_AND;
        write_back = 1'b1;
        flag_upd   = 1'b1;
      end
      OPC_OR: begin
        unit_sel   = UNIT_LOGIC;
        lop_sel    = LOP_OR;
        write_back = 1'b1;
        flag_upd   = 1'b1;
      end
      OPC_INV: begin
        unit_sel   = UNIT_LOGIC;
        lop_sel    = mode ? LOP_INV_OPND : LOP_INV_DST;
        write_back = 1'b1;
        flag_upd   = 1'b1;
      end
      OPC_CMP: begin
        unit_sel   = UNIT_ARITH;
        do_sub     = 1'b1;
        flag_upd   = 1'b1;
      end
      OPC_SHIFT: begin
        unit_sel    = UNIT_SHIFT;
        shift_right = mode;
        write_back  = 1'b1;
        flag_upd    = 1'b1;
      end
      default: begin
        unit_sel = UNIT_NONE;
      end
    endcase
  end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] y,
  output logic             cout
);

  localparam int EXT_W = WIDTH + 1;

  // Carry out of the top bit lands in bit WIDTH.
  function automatic logic [EXT_W-1:0] add_ext(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] z);
    return {1'b0, x} + {1'b0, z};
  endfunction

  // Bit WIDTH of the widened difference is set exactly when x < z.
  function automatic logic [EXT_W-1:0] sub_ext(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] z);
    return {1'b0, x} - {1'b0, z};
  endfunction

  logic [EXT_W-1:0] sum_w;
  logic [EXT_W-1:0] dif_w;

  always_comb begin
    sum_w = add_ext(a, b);
    dif_w = sub_ext(a, b);
    if (do_sub) begin
      y    = dif_w[WIDTH-1:0];
      cout = dif_w[WIDTH];
    end else begin
      y    = sum_w[WIDTH-1:0];
      cout = sum_w[WIDTH];
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  lop_e             lop_sel,
  output logic [WIDTH-1:0] y
);

  function automatic logic [WIDTH-1:0] bitop(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] z,
                                             input lop_e sel);
    case (sel)
      LOP_AND:      return x & z;
      LOP_OR:       return x | z;
      LOP_INV_DST:  return ~x;
      default:      return ~z;
    endcase
  endfunction

  assign y = bitop(a, b, lop_sel);

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] amt,
  input  logic             right,
  output logic [WIDTH-1:0] y,
  output logic             cout
);

  // Last bit pushed out of x by a shift of k places (0 when k is 0 or > WIDTH).
  function automatic logic last_out(input logic [WIDTH-1:0] x,
                                    input int unsigned k,
                                    input logic dir_r);
    logic bit_o;
    bit_o = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (dir_r && (k == unsigned'(i + 1)))
        bit_o = x[i];
      if (!dir_r && (k == unsigned'(WIDTH - i)))
        bit_o = x[i];
    end
    return bit_o;
  endfunction

  function automatic logic [WIDTH-1:0] zero_fill(input logic [WIDTH-1:0] x,
                                                 input int unsigned k,
                                                 input logic dir_r);
    if (k >= unsigned'(WIDTH))
      return '0;
    return dir_r ? (x >> k) : (x << k);
  endfunction

  int unsigned amt_u;

  always_comb begin
    amt_u = int'(amt);
    y     = zero_fill(a, amt_u, right);
    cout  = last_out(a, amt_u, right);
  end

endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t nxt,
  output flags_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur <= '0;
    else if (load)
      cur <= nxt;
  end

endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       opcode,
  input  logic             mode,
  input  logic [WIDTH-1:0] dst_val,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_n
);

  localparam int MSB = WIDTH - 1;

  unit_e            unit_sel;
  lop_e             lop_sel;
  logic             do_sub;
  logic             shift_right;
  logic             write_back;
  logic             flag_upd;

  logic [WIDTH-1:0] arith_y;
  logic             arith_c;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] shift_y;
  logic             shift_c;

  // Named internal events used by the checker.
  logic             flag_load;
  logic             res_zero;
  logic             carry_next;
  flags_t           flags_nxt;
  flags_t           flags_cur;

  alu8_decode u_dec (
    .opcode      (opcode),
    .mode        (mode),
    .unit_sel    (unit_sel),
    .do_sub      (do_sub),
    .lop_sel     (lop_sel),
    .shift_right (shift_right),
    .write_back  (write_back),
    .flag_upd    (flag_upd)
  );

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .a      (dst_val),
    .b      (operand),
    .do_sub (do_sub),
    .y      (arith_y),
    .cout   (arith_c)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a       (dst_val),
    .b       (operand),
    .lop_sel (lop_sel),
    .y       (logic_y)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .a     (dst_val),
    .amt   (operand),
    .right (shift_right),
    .y     (shift_y),
    .cout  (shift_c)
  );

  always_comb begin
    case (unit_sel)
      UNIT_ARITH: begin
        result     = arith_y;
        carry_next = arith_c;
      end
      UNIT_LOGIC: begin
        result     = logic_y;
        carry_next = 1'b0;
      end
      UNIT_SHIFT: begin
        result     = shift_y;
        carry_next = shift_c;
      end
      default: begin
        result     = '0;
        carry_next = 1'b0;
      end
    endcase
  end

  assign res_zero    = (result == '0);
  assign flags_nxt.z = res_zero;
  assign flags_nxt.c = carry_next;
  assign flags_nxt.n = result[MSB];

  assign flag_load = op_valid & flag_upd;
  assign wr_en     = op_valid & write_back;

  alu8_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (flag_load),
    .nxt   (flags_nxt),
    .cur   (flags_cur)
  );

  assign flag_z = flags_cur.z;
  assign flag_c = flags_cur.c;
  assign flag_n = flags_cur.n;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       opcode,
  input logic [WIDTH-1:0] operand,
  input logic [WIDTH-1:0] result,
  input logic             wr_en,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_n,
  input logic             flag_load
);

  logic alu_opc;
  assign alu_opc = (opcode >= 4'h3 && opcode <= 4'h8) || (opcode == 4'hA);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({flag_z, flag_c, flag_n}));

  // R9
  foreign_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !alu_opc) |=> $stable({flag_z, flag_c, flag_n}));

  // R9
  foreign_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !alu_opc) |-> !wr_en);

  // R5
  cmp_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 4'h8) |-> (!wr_en && flag_load));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (flag_z == ($past(result) == '0)));

  // R8
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (flag_n == $past(result[WIDTH-1])));

  // R3
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 4'h5 || opcode == 4'h6 || opcode == 4'h7)) |=> !flag_c);

  // R6
  wide_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 4'hA && operand >= WIDTH) |-> (result == '0 && wr_en));

endmodule

bind alu8_flags_unit alu8_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .operand   (operand),
  .result    (result),
  .wr_en     (wr_en),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_n    (flag_n),
  .flag_load (flag_load)
);

// File: tb/sim_alu8_flags_unit.sv
module sim_alu8_flags_unit;

  localparam int W = 8;

  typedef struct {
    logic [7:0] res;
    bit         chk_res;
    bit         wr;
    bit         z;
    bit         c;
    bit         n;
    string      req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [3:0]   opcode = 4'h0;
  logic         mode = 1'b0;
  logic [W-1:0] dst_val = '0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] result;
  logic         wr_en;
  logic         flag_z, flag_c, flag_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mz = 0, mc = 0, mn = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  alu8_flags_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .mode(mode),
    .dst_val(dst_val), .operand(operand), .result(result), .wr_en(wr_en),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Independent model written from the requirements with integer arithmetic.
  task automatic drive(bit v, int op, bit md, int d, int o, string req);
    exp_t e;
    int r;
    bit fl;
    bit cc;
    r = 0; fl = 0; cc = 0;
    e.wr = 0;
    if (v) begin
      case (op)
        3: begin r = d + o; cc = (r > 255); fl = 1; e.wr = 1; end
        4: begin r = d - o; cc = (d < o); fl = 1; e.wr = 1; end
        5: begin r = d & o; fl = 1; e.wr = 1; end
        6: begin r = d | o; fl = 1; e.wr = 1; end
        7: begin r = md ? (255 - o) : (255 - d); fl = 1; e.wr = 1; end
        8: begin r = d - o; cc = (d < o); fl = 1; end
        10: begin
          fl = 1; e.wr = 1;
          if (o == 0) r = d;
          else if (o >= 8) r = 0;
          else if (md) r = d / (1 << o);
          else r = (d * (1 << o)) % 256;
          if (o >= 1 && o <= 8)
            cc = md ? ((d >> (o - 1)) & 1) : ((d >> (8 - o)) & 1);
        end
        default: ;
      endcase
    end
    r = r & 255;
    if (fl) begin
      mz = (r == 0);
      mn = (r >= 128);
      mc = cc;
    end
    e.res = r[7:0];
    e.chk_res = e.wr;
    e.z = mz; e.c = mc; e.n = mn;
    e.req = req;
    @(negedge clk);
    op_valid = v;
    opcode   = op[3:0];
    mode     = md;
    dst_val  = d[7:0];
    operand  = o[7:0];
    q.push_back(e);
  endtask

  // Monitor: just after each rising edge the combinational outputs still
  // reflect the inputs driven at the preceding falling edge, and the flags
  // reflect that edge's update.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk_res) check(e.req, "result", int'(result), int'(e.res));
        check(e.req, "wr_en", int'(wr_en), int'(e.wr));
        check(e.req, "Z", int'(flag_z), int'(e.z));
        check(e.req, "C", int'(flag_c), int'(e.c));
        check(e.req, "N", int'(flag_n), int'(e.n));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: flags cleared in reset
    check("R11", "flags in reset", int'({flag_z, flag_c, flag_n}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "flags after reset", int'({flag_z, flag_c, flag_n}), 0);

    // R1 add
    drive(1, 3, 1, 8'h10, 8'h20, "R1");
    drive(1, 3, 0, 8'hFF, 8'h01, "R1");
    drive(1, 3, 0, 8'h80, 8'h80, "R1");
    drive(1, 3, 1, 8'h7F, 8'h01, "R1");
    // R2 subtract
    drive(1, 4, 0, 8'h05, 8'h05, "R2");
    drive(1, 4, 1, 8'h03, 8'h05, "R2");
    drive(1, 4, 0, 8'h80, 8'h01, "R2");
    // R3 AND/OR clear a carry set just before
    drive(1, 3, 0, 8'hFF, 8'h02, "R1");
    drive(1, 5, 0, 8'hF0, 8'h3C, "R3");
    drive(1, 3, 0, 8'hFF, 8'h02, "R1");
    drive(1, 6, 1, 8'h00, 8'h00, "R3");
    drive(1, 6, 0, 8'h81, 8'h02, "R3");
    // R4 inversion
    drive(1, 7, 0, 8'h0F, 8'hAA, "R4");
    drive(1, 7, 0, 8'h0F, 8'h00, "R4");
    drive(1, 7, 0, 8'hFF, 8'h12, "R4");
    drive(1, 7, 1, 8'h00, 8'h55, "R4");
    // R5 compare
    drive(1, 8, 0, 8'h03, 8'h05, "R5");
    drive(1, 8, 1, 8'h07, 8'h07, "R5");
    drive(1, 8, 0, 8'h90, 8'h10, "R5");
    // R6 / R7 shifts
    drive(1, 10, 0, 8'h81, 1, "R6");
    drive(1, 10, 1, 8'h81, 1, "R7");
    drive(1, 10, 0, 8'hA5, 0, "R7");
    drive(1, 10, 0, 8'h01, 8, "R7");
    drive(1, 10, 1, 8'h80, 8, "R7");
    drive(1, 10, 0, 8'hFF, 9, "R6");
    drive(1, 10, 1, 8'hFF, 200, "R6");
    drive(1, 10, 1, 8'hB4, 3, "R6");
    drive(1, 10, 0, 8'h0B, 4, "R6");
    // R8 flags follow the latest flag-affecting result
    drive(1, 4, 0, 8'h00, 8'h01, "R8");
    drive(1, 5, 1, 8'h0F, 8'hF0, "R8");
    // R9 foreign opcodes leave flags alone
    drive(1, 3, 0, 8'hF0, 8'h20, "R1");
    drive(1, 0, 1, 8'h00, 8'h00, "R9");
    drive(1, 9, 0, 8'h00, 8'h00, "R9");
    drive(1, 11, 0, 8'h44, 8'h10, "R9");
    drive(1, 15, 0, 8'h00, 8'h00, "R9");
    drive(1, 2, 1, 8'hFF, 8'hFF, "R9");
    // R10 idle cycles hold flags
    drive(0, 3, 0, 8'h00, 8'h00, "R10");
    drive(0, 4, 0, 8'h01, 8'h05, "R10");
    drive(1, 8, 0, 8'h00, 8'h00, "R8");
    drive(0, 10, 0, 8'h80, 8'h01, "R10");

    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule